// File: doc/BRIEF.md
# Millisecond Interval Timer with Auto-Reload

This block is a periodic interrupt source for a system clocked at a fixed, known frequency. A prescaler divides the system clock down to a one-millisecond enable. A millisecond counter then counts enables against a 9-bit reload value, so each period lasts (reload + 1) milliseconds. When a period ends, the block raises an interrupt line and starts the next period in the same cycle, without any action from software.

Software drives the block through a small register port with two addresses. A write to the reload address stores a new period and restarts timing from zero. A read of the count address returns the number of whole milliseconds elapsed in the current period. Two events clear the interrupt: that read, and any write of a new reload value. The interrupt stays asserted until one of them occurs.

Top module: `ms_interval_timer`

## Requirements
- R1: After reset the interrupt is low, and both the reload value and the millisecond count read back as 0.
- R2: A write to address 0 (reload) keeps only wdata[8:0]. A read of address 0 returns the stored value in rdata[8:0], with rdata[31:9] zero.
- R3: Let DIV = CLK_HZ / TICK_HZ. After a reload write sampled at clock edge E, the interrupt first rises at edge E + (reload+1)*DIV. This holds at the boundary values reload = 0 and reload = 511.
- R4: Without any new write, the interrupt rises again at every further multiple of (reload+1)*DIV cycles after E.
- R5: Once raised, the interrupt stays high across later expiries until it is acknowledged.
- R6: A read of address 1 (count) clears the interrupt at the edge where the read is sampled. A read of address 0 leaves the interrupt unchanged.
- R7: A reload write clears the interrupt at its edge and restarts both the prescaler and the millisecond count.
- R8: If an expiry and a count read fall on the same edge, the interrupt is high after that edge.
- R9: A read of address 1 returns, combinationally, the whole milliseconds elapsed since the current period began. This value lies in the range 0 to reload.
- R10: A write to address 1 has no effect: the reload value, the interrupt and the timing of the next expiry are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; a read of address 1 acknowledges the interrupt |
| addr | input | 1 | Register select: 0 = reload, 1 = count |
| wdata | input | DATA_W | Write data; only the low RELOAD_W bits are kept |
| rdata | output | DATA_W | Combinational read data for the selected register |
| irq | output | 1 | Sticky interrupt, raised at each expiry |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle, and that both are low while rst is high. The property that rejects any rise without a prior expiry also assumes that an expiry is the only way the interrupt can rise. Every bench task raises exactly one strobe for exactly one cycle, changes inputs only on falling edges, and leaves all strobes low during reset. For R8, the bench places the coincident read by counting cycles from a known reload write, not by watching the interrupt.

// File: rtl/ms_tmr_pkg.sv
package ms_tmr_pkg;

    typedef enum logic {
        ADDR_RELOAD = 1'b0,
        ADDR_COUNT  = 1'b1
    } tmr_addr_e;

endpackage

// File: rtl/ms_tmr_prescaler.sv
module ms_tmr_prescaler #(
    parameter int CLK_HZ  = 125_000_000,
    parameter int TICK_HZ = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic tick_o
);
    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.cnt == PW'(DIV - 1));
        if (restart_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ms_tmr_period.sv
module ms_tmr_period #(
    parameter int RELOAD_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                restart_i,
    input  logic [RELOAD_W-1:0] reload_i,
    output logic [RELOAD_W-1:0] count_o,
    output logic                expire_o
);
    typedef struct packed {
        logic [RELOAD_W-1:0] ms;
    } per_t;

    per_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = tick_i && !restart_i && (st_q.ms == reload_i);
        if (restart_i || expire_o) begin
            st_d.ms = '0;
        end else if (tick_i) begin
            st_d.ms = st_q.ms + 1'b1;
        end
        count_o = st_q.ms;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
    import ms_tmr_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int TICK_HZ  = 1000,
    parameter int RELOAD_W = 9,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int PAD_W = DATA_W - RELOAD_W;

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic                irq;
    } top_t;

    top_t st_d, st_q;

    logic                tick;
    logic                expire;
    logic                wr_reload;
    logic                rd_ack;
    logic [RELOAD_W-1:0] count;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:RELOAD_W];

    ms_tmr_prescaler #(
        .CLK_HZ  (CLK_HZ),
        .TICK_HZ (TICK_HZ)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .restart_i (wr_reload),
        .tick_o    (tick)
    );

    ms_tmr_period #(
        .RELOAD_W (RELOAD_W)
    ) u_per (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .restart_i (wr_reload),
        .reload_i  (st_q.reload),
        .count_o   (count),
        .expire_o  (expire)
    );

    always_comb begin
        st_d      = st_q;
        wr_reload = wr_en && (tmr_addr_e'(addr) == ADDR_RELOAD);
        rd_ack    = rd_en && (tmr_addr_e'(addr) == ADDR_COUNT);
        if (wr_reload) begin
            st_d.reload = wdata[RELOAD_W-1:0];
            st_d.irq    = 1'b0;
        end else if (expire) begin
            st_d.irq = 1'b1;
        end else if (rd_ack) begin
            st_d.irq = 1'b0;
        end
        if (tmr_addr_e'(addr) == ADDR_COUNT) begin
            rdata = {{PAD_W{1'b0}}, count};
        end else begin
            rdata = {{PAD_W{1'b0}}, st_q.reload};
        end
        irq = st_q.irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ms_interval_timer_chk.sv
module ms_interval_timer_chk #(
    parameter int RELOAD_W = 9,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                rd_en,
    input logic                addr,
    input logic [DATA_W-1:0]   wdata,
    input logic                irq,
    input logic                expire,
    input logic [RELOAD_W-1:0] count,
    input logic [RELOAD_W-1:0] reload_q
);
    p_reload_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr) |=> (reload_q == $past(wdata[RELOAD_W-1:0])));

    p_write_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr) |=> !irq);

    p_rise_needs_expiry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(expire));

    p_expiry_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (expire && !rd_en) |=> irq);

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && !(rd_en && addr) && !(wr_en && !addr)) |=> irq);

    p_read_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr && !expire && !wr_en) |=> !irq);

    p_expiry_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (expire && rd_en && addr) |=> irq);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count <= reload_q);

    p_ignored_write_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr) |=> (reload_q == $past(reload_q)));

endmodule

bind ms_interval_timer ms_interval_timer_chk #(
    .RELOAD_W (RELOAD_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .expire   (expire),
    .count    (count),
    .reload_q (st_q.reload)
);

// File: tb/ms_interval_timer_bench.sv
`timescale 1ns/1ps
module ms_interval_timer_bench;
    localparam int CLK_HZ  = 8000;
    localparam int TICK_HZ = 1000;
    localparam int DIV     = CLK_HZ / TICK_HZ;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ms_interval_timer #(
        .CLK_HZ  (CLK_HZ),
        .TICK_HZ (TICK_HZ)
    ) u_ms_interval_timer (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic bus_write(input logic a, input logic [31:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 20000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        idle(3);
        rst = 1'b0;
        chk("R1 irq low", {31'd0, irq}, 32'd0);
        bus_read(1'b0, v);
        chk("R1 reload zero", v, 32'd0);
        bus_read(1'b1, v);
        chk("R1 count zero", v, 32'd0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        int n;
        // Write edge E; reload keeps 0x603 & 0x1FF = 3, period 32 cycles.
        bus_write(1'b0, 32'hABCD_E603);
        wait_irq(n);
        chk("R3 first expiry", n, 4 * DIV);
        bus_read(1'b0, v);
        chk("R2 masked reload", v, 32'd3);
        chk("R6 reload read keeps irq", {31'd0, irq}, 32'd1);
        idle(40);
        chk("R5 sticky over expiry", {31'd0, irq}, 32'd1);
        bus_read(1'b1, v);
        chk("R9 elapsed ms", v, 32'd1);
        chk("R6 count read clears", {31'd0, irq}, 32'd0);
        wait_irq(n);
        chk("R4 auto rearm", n, 22);
    endtask

    task automatic t_restart();
        int n;
        bus_write(1'b0, 32'd1);
        chk("R7 write clears irq", {31'd0, irq}, 32'd0);
        wait_irq(n);
        chk("R7 restart period", n, 2 * DIV);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        int n;
        bus_write(1'b1, 32'd7);
        chk("R10 irq kept", {31'd0, irq}, 32'd1);
        bus_read(1'b0, v);
        chk("R10 reload kept", v, 32'd1);
        bus_read(1'b1, v);
        wait_irq(n);
        chk("R10 timing kept", n, 13);
    endtask

    task automatic t_coincide();
        logic [31:0] v;
        idle(15);
        bus_read(1'b1, v);
        chk("R8 expiry beats ack", {31'd0, irq}, 32'd1);
        bus_read(1'b1, v);
        chk("R6 later ack clears", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_bounds();
        int n;
        bus_write(1'b0, 32'd0);
        wait_irq(n);
        chk("R3 reload zero period", n, DIV);
        bus_write(1'b0, 32'h0000_01FF);
        wait_irq(n);
        chk("R3 reload max period", n, 512 * DIV);
    endtask

    initial begin
        t_reset();
        t_periodic();
        t_restart();
        t_ignored();
        t_coincide();
        t_bounds();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule